// File: doc/BRIEF.md
# Serial Zero-Suppression Event Packer

This block sits between a 32-channel time-to-digital converter and an output FIFO. Once per reference period, a boundary strobe tells it to take a copy of every channel's valid flag and 5-bit drift time into a snapshot register. The converter can then carry on with the next period while the packer works on the copy. The packer first writes one hit-pattern word, with one bit per channel, to the FIFO. It then steps through the channels one per clock, lowest index first, and writes a drift-time word only for channels whose flag was set. Channels without hits add nothing to the output.

Before it writes anything, the packer counts the hits in the snapshot and compares the record length with the free space the FIFO reports. A record that would not fit is dropped whole, so the FIFO never holds part of an event. A drop sets a sticky loss flag. A boundary strobe that arrives while a record is still being built is not taken and also sets that flag. A full record occupies the packer for 33 cycles, so the packer clock must give at least that many cycles per reference period.

Top module: `zs_packer`

## Requirements
- R1: While reset is asserted and after it is released, `fifo_wr`, `busy` and `lost` are 0.
- R2: A `frame` pulse sampled at a clock edge while `busy` is 0 captures `ch_valid` and `ch_time`, and `busy` is 1 from that edge onward. Changes on `ch_valid` and `ch_time` after that edge have no effect on the record.
- R3: In the cycle right after the capture edge, `fifo_wr` is 1 and `fifo_wdata` holds the hit pattern, with bit i equal to the captured valid flag of channel i.
- R4: The pattern is followed by one word per set flag, in ascending channel order. Channel i's word is presented in the cycle that starts i+1 edges after the capture edge. Bits [4:0] of that word hold the drift time of channel i (`ch_time[5*i+4:5*i]`), and all higher bits are 0.
- R5: An event with no hits produces exactly one word, and that word is all zeros.
- R6: If `fifo_space` in the cycle after capture is less than 1 plus the hit count, no word of the event is written and `lost` becomes 1.
- R7: A `frame` sampled while `busy` is 1 is ignored: the record in progress is unchanged. `lost` becomes 1 and stays 1 until reset.
- R8: When `fifo_space` equals 1 plus the hit count exactly, the whole record is written. `busy` returns to 0 33 edges after capture, and a new `frame` is accepted after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Packer clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| frame | input | 1 | Reference period boundary strobe |
| ch_valid | input | 32 | Per-channel hit flags |
| ch_time | input | 160 | Per-channel drift times, channel i at bits [5i+4:5i] |
| fifo_space | input | 8 | Free words currently available in the output FIFO |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_wdata | output | 32 | FIFO write word |
| busy | output | 1 | A record is being admitted or scanned |
| lost | output | 1 | Sticky flag: an event was dropped or a strobe was missed |

## Verification
The hardest cases to reach are a second boundary strobe that lands in the middle of a scan, and an admission check that is on the exact edge between fitting and not fitting. The stimulus pulses `frame` a few cycles into a scan with a different hit pattern. It then checks that the record on the FIFO side matches the first snapshot word for word, and that `lost` is set. Table entries place `fifo_space` one word below and exactly at the record length. After every capture the channel inputs are inverted, so any leak from the live inputs into the snapshot shows up in the data.

// File: rtl/zs_pkg.sv
package zs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHECK = 2'd1,
    ST_SCAN  = 2'd2
  } zs_state_e;
endpackage

// File: rtl/zs_snapshot.sv
module zs_snapshot #(
  parameter int NCH = 32,
  parameter int TW  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [NCH-1:0]    ch_valid,
  input  logic [NCH*TW-1:0] ch_time,
  output logic [NCH-1:0]    snap_valid,
  output logic [NCH*TW-1:0] snap_time
);
  logic [NCH-1:0]    valid_q;
  logic [NCH*TW-1:0] time_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      time_q  <= '0;
    end else if (take) begin
      valid_q <= ch_valid;
      time_q  <= ch_time;
    end
  end

  assign snap_valid = valid_q;
  assign snap_time  = time_q;
endmodule

// File: rtl/zs_admit.sv
module zs_admit #(
  parameter int NCH = 32,
  parameter int SPW = 8
) (
  input  logic [NCH-1:0] snap_valid,
  input  logic [SPW-1:0] fifo_space,
  output logic           fits
);
  localparam int CW = $clog2(NCH + 1);

  logic [CW-1:0]  hit_cnt;
  logic [SPW-1:0] rec_len;

  always_comb begin
    hit_cnt = '0;
    for (int i = 0; i < NCH; i++) begin
      hit_cnt = hit_cnt + CW'(snap_valid[i]);
    end
  end

  assign rec_len = SPW'(hit_cnt) + SPW'(1);
  assign fits    = (fifo_space >= rec_len);
endmodule

// File: rtl/zs_ctrl.sv
module zs_ctrl
  import zs_pkg::*;
#(
  parameter int NCH = 32,
  localparam int IW = $clog2(NCH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame,
  input  logic          fits,
  output logic          take,
  output zs_state_e     st,
  output logic [IW-1:0] idx,
  output logic          lost
);
  localparam logic [IW-1:0] LAST = IW'(NCH - 1);

  zs_state_e     st_q, st_n;
  logic [IW-1:0] idx_q, idx_n;
  logic          idx_en;
  logic          lost_q, lost_n;

  always_comb begin
    st_n   = st_q;
    idx_n  = idx_q;
    lost_n = lost_q;
    take   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (frame) begin
          take = 1'b1;
          st_n = ST_CHECK;
        end
      end
      ST_CHECK: begin
        idx_n = '0;
        if (fits) begin
          st_n = ST_SCAN;
        end else begin
          st_n   = ST_IDLE;
          lost_n = 1'b1;
        end
      end
      ST_SCAN: begin
        if (idx_q == LAST) begin
          st_n = ST_IDLE;
        end else begin
          idx_n = idx_q + IW'(1);
        end
      end
      default: st_n = ST_IDLE;
    endcase
    if (st_q != ST_IDLE && frame) begin
      lost_n = 1'b1;
    end
  end

  assign idx_en = (st_q != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      lost_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      lost_q <= lost_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (idx_en) begin
      idx_q <= idx_n;
    end
  end

  assign st   = st_q;
  assign idx  = idx_q;
  assign lost = lost_q;

  assert_idx_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SCAN && idx_q != LAST) |=> (st_q == ST_SCAN && idx_q == $past(idx_q) + IW'(1)));

  assert_lost_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lost_q |=> lost_q);

  assert_busy_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_IDLE && frame) |=> lost_q);
endmodule

// File: rtl/zs_emit.sv
module zs_emit
  import zs_pkg::*;
#(
  parameter int NCH = 32,
  parameter int TW  = 5,
  parameter int DW  = 32,
  localparam int IW = $clog2(NCH)
) (
  input  zs_state_e         st,
  input  logic [IW-1:0]     idx,
  input  logic              fits,
  input  logic [NCH-1:0]    snap_valid,
  input  logic [NCH*TW-1:0] snap_time,
  output logic              wr,
  output logic [DW-1:0]     wdata
);
  always_comb begin
    wr    = 1'b0;
    wdata = '0;
    if (st == ST_CHECK) begin
      wr    = fits;
      wdata = DW'(snap_valid);
    end else if (st == ST_SCAN) begin
      wr    = snap_valid[idx];
      wdata = DW'(snap_time[idx*TW +: TW]);
    end
  end
endmodule

// File: rtl/zs_packer.sv
module zs_packer
  import zs_pkg::*;
#(
  parameter int NCH = 32,
  parameter int TW  = 5,
  parameter int DW  = 32,
  parameter int SPW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame,
  input  logic [NCH-1:0]    ch_valid,
  input  logic [NCH*TW-1:0] ch_time,
  input  logic [SPW-1:0]    fifo_space,
  output logic              fifo_wr,
  output logic [DW-1:0]     fifo_wdata,
  output logic              busy,
  output logic              lost
);
  localparam int IW = $clog2(NCH);

  logic [1:0]        rst_sync;
  logic              rst_int_n;
  logic              take;
  logic              fits;
  zs_state_e         st;
  logic [IW-1:0]     idx;
  logic [NCH-1:0]    snap_valid;
  logic [NCH*TW-1:0] snap_time;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= 2'b00;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync[1];

  zs_snapshot #(.NCH(NCH), .TW(TW)) snap_i (
    .clk(clk), .rst_n(rst_int_n), .take(take),
    .ch_valid(ch_valid), .ch_time(ch_time),
    .snap_valid(snap_valid), .snap_time(snap_time)
  );

  zs_admit #(.NCH(NCH), .SPW(SPW)) admit_i (
    .snap_valid(snap_valid), .fifo_space(fifo_space), .fits(fits)
  );

  zs_ctrl #(.NCH(NCH)) ctrl_i (
    .clk(clk), .rst_n(rst_int_n), .frame(frame), .fits(fits),
    .take(take), .st(st), .idx(idx), .lost(lost)
  );

  zs_emit #(.NCH(NCH), .TW(TW), .DW(DW)) emit_i (
    .st(st), .idx(idx), .fits(fits),
    .snap_valid(snap_valid), .snap_time(snap_time),
    .wr(fifo_wr), .wdata(fifo_wdata)
  );

  assign busy = (st != ST_IDLE);

  // Word counter for the current record, used only by the checks below
  logic [SPW-1:0] chk_cnt;
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      chk_cnt <= '0;
    end else if (take) begin
      chk_cnt <= '0;
    end else if (fifo_wr) begin
      chk_cnt <= chk_cnt + SPW'(1);
    end
  end

  assert_wr_busy_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    fifo_wr |-> busy);

  assert_snap_hold_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (busy && frame) |=> $stable(snap_valid));

  assert_whole_record_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    $fell(busy) |-> (chk_cnt == '0 || int'(chk_cnt) == 1 + $countones(snap_valid)));
endmodule

// File: tb/zs_packer_tb_top.sv
module zs_packer_tb_top;
  localparam int NCH = 32;
  localparam int TW  = 5;
  localparam int DW  = 32;
  localparam int SPW = 8;
  localparam int NV  = 6;

  localparam logic [31:0] TV_VALID [0:NV-1] = '{
    32'hFFFF_FFFF, 32'h8000_0001, 32'h0000_0000,
    32'hA5A5_5A5A, 32'h0000_0F00, 32'h0000_0010 };
  localparam int TV_SEED  [0:NV-1] = '{3, 7, 9, 11, 1, 13};
  localparam int TV_SPACE [0:NV-1] = '{40, 40, 1, 17, 4, 2};

  logic              clk;
  logic              rst_n;
  logic              frame;
  logic [NCH-1:0]    ch_valid;
  logic [NCH*TW-1:0] ch_time;
  logic [SPW-1:0]    fifo_space;
  logic              fifo_wr;
  logic [DW-1:0]     fifo_wdata;
  logic              busy;
  logic              lost;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  int wtot  = 0;
  logic [DW-1:0] wlog [0:1023];
  int            wcyc [0:1023];

  zs_packer #(.NCH(NCH), .TW(TW), .DW(DW), .SPW(SPW)) dut_i (
    .clk(clk), .rst_n(rst_n), .frame(frame), .ch_valid(ch_valid),
    .ch_time(ch_time), .fifo_space(fifo_space), .fifo_wr(fifo_wr),
    .fifo_wdata(fifo_wdata), .busy(busy), .lost(lost)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 200000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: actual cycles=%0d expected below 200000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (fifo_wr) begin
      wlog[wtot & 1023] = fifo_wdata;
      wcyc[wtot & 1023] = cyc;
      wtot = wtot + 1;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [TW-1:0] tval(input int ch, input int seed);
    return TW'((ch * seed + ch / 3 + seed) & 31);
  endfunction

  function automatic logic [NCH*TW-1:0] tvec(input int seed);
    logic [NCH*TW-1:0] v;
    for (int i = 0; i < NCH; i++) v[i*TW +: TW] = tval(i, seed);
    return v;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    frame = 1'b0;
    @(negedge clk);
    check(fifo_wr == 1'b0 && busy == 1'b0 && lost == 1'b0, "R1 in reset",
          {29'd0, fifo_wr, busy, lost}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(fifo_wr == 1'b0 && busy == 1'b0 && lost == 1'b0, "R1 after reset",
          {29'd0, fifo_wr, busy, lost}, 32'd0);
  endtask

  // One event; intrude pulses a second frame a few cycles into the scan
  task automatic run_event(input logic [31:0] valid, input int seed, input int space, input bit intrude);
    int start, c0, pop, n, k;
    bit ok_fit;
    @(negedge clk);
    ch_valid   = valid;
    ch_time    = tvec(seed);
    fifo_space = SPW'(space);
    frame      = 1'b1;
    start      = wtot;
    c0         = cyc;
    @(negedge clk);
    frame    = 1'b0;
    ch_valid = ~valid;
    ch_time  = ~tvec(seed);
    check(busy == 1'b1, "R2 busy after capture", {31'd0, busy}, 32'd1);
    if (intrude) begin
      repeat (3) @(negedge clk);
      ch_valid = 32'hFFFF_0000;
      frame    = 1'b1;
      @(negedge clk);
      frame = 1'b0;
      repeat (32) @(negedge clk);
    end else begin
      repeat (36) @(negedge clk);
    end
    check(busy == 1'b0, "R8 busy low after record", {31'd0, busy}, 32'd0);
    pop = $countones(valid);
    ok_fit = (space >= pop + 1);
    n = wtot - start;
    if (ok_fit) begin
      check(n == pop + 1, "R4 record length", 32'(n), 32'(pop + 1));
      if (n >= 1) begin
        check(wlog[start & 1023] == valid, "R3 pattern word", wlog[start & 1023], valid);
        check(wcyc[start & 1023] == c0 + 1, "R3 pattern timing", 32'(wcyc[start & 1023]), 32'(c0 + 1));
      end
      if (pop == 0) check(n == 1 && wlog[start & 1023] == '0, "R5 empty event word", 32'(n), 32'd1);
      k = 1;
      for (int i = 0; i < NCH; i++) begin
        if (valid[i] && k < n) begin
          check(wlog[(start + k) & 1023] == DW'(tval(i, seed)), "R4 drift word",
                wlog[(start + k) & 1023], DW'(tval(i, seed)));
          check(wcyc[(start + k) & 1023] == c0 + 2 + i, "R4 drift timing",
                32'(wcyc[(start + k) & 1023]), 32'(c0 + 2 + i));
          k = k + 1;
        end
      end
    end else begin
      check(n == 0, "R6 dropped event writes nothing", 32'(n), 32'd0);
      check(lost == 1'b1, "R6 loss flag on drop", {31'd0, lost}, 32'd1);
    end
    if (intrude) check(lost == 1'b1, "R7 loss flag on missed frame", {31'd0, lost}, 32'd1);
  endtask

  initial begin
    frame      = 1'b0;
    ch_valid   = '0;
    ch_time    = '0;
    fifo_space = '0;
    rst_n      = 1'b0;
    do_reset();

    for (int v = 0; v < NV; v++) begin
      run_event(TV_VALID[v], TV_SEED[v], TV_SPACE[v], 1'b0);
    end
    // R7: loss flag stays set across a later good event
    check(lost == 1'b1, "R7 loss flag sticky", {31'd0, lost}, 32'd1);

    do_reset();
    check(lost == 1'b0, "R1 reset clears loss", {31'd0, lost}, 32'd0);
    run_event(32'h0000_00F0, 5, 40, 1'b1);

    // R1: reset in the middle of a scan
    do_reset();
    @(negedge clk);
    ch_valid = 32'hFFFF_FFFF; ch_time = tvec(2); fifo_space = 8'd40; frame = 1'b1;
    @(negedge clk);
    frame = 1'b0;
    repeat (5) @(negedge clk);
    do_reset();
    // R8: back-to-back events, second one just fits
    run_event(32'h0000_0003, 6, 3, 1'b0);
    run_event(32'h1000_0000, 4, 2, 1'b0);
    check(lost == 1'b0, "R8 no loss on exact fit", {31'd0, lost}, 32'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule